// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word addresses of a four-beat burst from one captured starting address. A load strobe registers a full word address. After that, an active-low step input moves the two least-significant address bits to the next beat, or holds them to pause the burst. The upper address bits stay as loaded for the whole burst.

The order of the two low bits is set by a static order-select input. Low gives a linear order: the start value plus the beat number, modulo 4. High gives an interleaved order: the start value XORed with the beat number. Both orders return to the starting low bits after the fourth beat and never carry into the upper bits. A flag marks the fourth beat.

The block is meant for the address path of a cache-style synchronous burst memory controller or memory model. It has no storage array, chip-select logic or data path.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets `addr_o` to zero and `last_beat_o` to 0 from the first edge where `rst` is sampled high.
- R2: On an edge where `load_i` is high, the whole of `addr_i` is captured. From the next cycle `addr_o` equals that value and the burst is at its first beat.
- R3: On an edge where `load_i` is high, `step_n_i` has no effect. The first beat shows the loaded low bits even if `step_n_i` was 0 on that edge.
- R4: On an edge without load, `step_n_i` = 0 advances the burst by one beat. `step_n_i` = 1 leaves `addr_o` and `last_beat_o` unchanged.
- R5: With `order_sel_i` = 0 (linear), beat k shows low bits (start + k) mod 4. For example, start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2.
- R6: With `order_sel_i` = 1 (interleaved), beat k shows low bits start XOR k. For example, start 1 gives 1,0,3,2 and start 2 gives 2,3,0,1.
- R7: Bits `addr_o[ADDR_W-1:2]` never change except on a load, even when the low bits roll over from 3 to 0.
- R8: One step after the fourth beat, the low bits return to the captured starting value in both orders.
- R9: `last_beat_o` is 1 exactly while the burst is at its fourth beat (beat index 3), and 0 on the other beats.
- R10: A load during a burst abandons the burst. The next cycle shows the new address at its first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture `addr_i` as the start of a new burst |
| addr_i | input | ADDR_W | Starting word address |
| step_n_i | input | 1 | Active-low advance; 1 holds the current beat |
| order_sel_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst word address |
| last_beat_o | output | 1 | High on the fourth beat of the burst |

## Verification
The bound checker examines every cycle:
- the first beat after a load shows the captured address;
- a held step freezes the outputs;
- the upper bits never move without a load;
- a step advances the beat index by one;
- in linear order each step adds one to the low bits;
- a step taken on the last beat restores the starting low bits.

The exact beat sequences of the two orders need directed bursts from chosen starting values, which only the bench scenarios provide. The same applies to the interleaved order, to the reset value and to the placement of the last-beat flag.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int BEAT_W    = 2;
  localparam int NUM_BEATS = 1 << BEAT_W;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  function automatic logic [BEAT_W-1:0] linear_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    return start + beat;
  endfunction

  function automatic logic [BEAT_W-1:0] xor_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    return start ^ beat;
  endfunction

  function automatic logic [BEAT_W-1:0] beat_next(
    input logic [BEAT_W-1:0] beat
  );
    return beat + 1'b1;
  endfunction

  function automatic logic beat_is_final(
    input logic [BEAT_W-1:0] beat
  );
    return beat == BEAT_W'(NUM_BEATS - 1);
  endfunction

endpackage

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ADDR_W-1:BEAT_W]   base_o,
  output logic [BEAT_W-1:0]        start_o
);

  logic [ADDR_W-1:BEAT_W] base_q;
  logic [BEAT_W-1:0]      start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
    end else if (load_i) begin
      base_q  <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
    end
  end

  assign base_o  = base_q;
  assign start_o = start_q;

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_n_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              final_o
);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (load_i) begin
      beat_q <= '0;
    end else if (!step_n_i) begin
      beat_q <= beat_next(beat_q);
    end
  end

  assign beat_o  = beat_q;
  assign final_o = beat_is_final(beat_q);

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic              order_sel_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_bits;

  assign lin_low = linear_low(start_i, beat_i);

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor_bit
      assign xor_bits[gi] = start_i[gi] ^ beat_i[gi];
    end
  endgenerate

  always_comb begin
    unique case (order_e'(order_sel_i))
      ORDER_XOR:    low_o = xor_bits;
      ORDER_LINEAR: low_o = lin_low;
      default:      low_o = lin_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_n_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_beat_o
);

  logic [ADDR_W-1:BEAT_W] base_w;
  logic [BEAT_W-1:0]      start_w;
  logic [BEAT_W-1:0]      beat_w;
  logic [BEAT_W-1:0]      low_w;
  logic                   final_w;

  // named events for the bound checker
  logic load_evt;
  logic step_evt;
  logic hold_evt;

  assign load_evt = load_i;
  assign step_evt = !load_i && !step_n_i;
  assign hold_evt = !load_i && step_n_i;

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .addr_i  (addr_i),
    .base_o  (base_w),
    .start_o (start_w)
  );

  burst_beat_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .step_n_i (step_n_i),
    .beat_o   (beat_w),
    .final_o  (final_w)
  );

  burst_order_map u_map (
    .order_sel_i (order_sel_i),
    .start_i     (start_w),
    .beat_i      (beat_w),
    .low_o       (low_w)
  );

  assign addr_o      = {base_w, low_w};
  assign last_beat_o = final_w;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_beat_o,
  input logic              load_evt,
  input logic              step_evt,
  input logic              hold_evt,
  input logic [BEAT_W-1:0] beat_w,
  input logic [BEAT_W-1:0] start_w
);

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (addr_o == $past(addr_i)) && (beat_w == '0));

  assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    hold_evt |=> $stable(addr_o) && $stable(last_beat_o));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> beat_w == $past(beat_w) + 1'b1);

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step_evt && !order_sel_i) |=>
      addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1);

  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  assert_wrap_start_R8: assert property (@(posedge clk) disable iff (rst)
    (step_evt && last_beat_o) |=> addr_o[BEAT_W-1:0] == start_w);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .order_sel_i (order_sel_i),
  .addr_i      (addr_i),
  .addr_o      (addr_o),
  .last_beat_o (last_beat_o),
  .load_evt    (load_evt),
  .step_evt    (step_evt),
  .hold_evt    (hold_evt),
  .beat_w      (beat_w),
  .start_w     (start_w)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic [AW-1:0] addr_i;
  logic          step_n_i;
  logic          order_sel_i;
  logic [AW-1:0] addr_o;
  logic          last_beat_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .addr_i      (addr_i),
    .step_n_i    (step_n_i),
    .order_sel_i (order_sel_i),
    .addr_o      (addr_o),
    .last_beat_o (last_beat_o)
  );

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic tick(input logic ld, input logic [AW-1:0] a, input logic sn);
    load_i   = ld;
    addr_i   = a;
    step_n_i = sn;
    @(negedge clk);
    load_i   = 1'b0;
    step_n_i = 1'b1;
  endtask

  // expected low bits, worked out beat by beat
  function automatic logic [1:0] model_low(input logic [1:0] s, input int k,
                                           input logic mode);
    logic [1:0] v;
    v = s;
    if (mode) begin
      v = s ^ 2'(k);
    end else begin
      for (int i = 0; i < k; i++) v = (v == 2'd3) ? 2'd0 : v + 2'd1;
    end
    return v;
  endfunction

  task automatic run_burst(input logic [AW-1:0] a, input logic mode,
                           input string req);
    order_sel_i = mode;
    tick(1'b1, a, 1'b1);
    for (int k = 0; k <= 4; k++) begin
      check(req, addr_o, {a[AW-1:2], model_low(a[1:0], k, mode)});
      check("R9", AW'(last_beat_o), AW'(k == 3));
      if (k == 4) check("R8", AW'(addr_o[1:0]), AW'(a[1:0]));
      if (k < 4) tick(1'b0, '0, 1'b0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(1'b0, '0, 1'b1);
    tick(1'b0, '0, 1'b1);
    check("R1 addr", addr_o, '0);
    check("R1 last", AW'(last_beat_o), '0);
    rst = 1'b0;
  endtask

  task automatic t_load_ignores_step();
    order_sel_i = 1'b0;
    tick(1'b1, 17'h0A5A6, 1'b0);
    check("R3", addr_o, 17'h0A5A6);
    check("R2", AW'(last_beat_o), '0);
  endtask

  task automatic t_hold();
    order_sel_i = 1'b1;
    tick(1'b1, 17'h12341, 1'b1);
    tick(1'b0, '0, 1'b0);
    check("R4 step", addr_o, 17'h12340);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, '0, 1'b1);
      check("R4 hold", addr_o, 17'h12340);
    end
    tick(1'b0, '0, 1'b0);
    check("R4 resume", addr_o, 17'h12343);
  endtask

  task automatic t_reload();
    order_sel_i = 1'b0;
    tick(1'b1, 17'h00100, 1'b1);
    tick(1'b0, '0, 1'b0);
    tick(1'b0, '0, 1'b0);
    tick(1'b1, 17'h1F003, 1'b0);
    check("R10 addr", addr_o, 17'h1F003);
    tick(1'b0, '0, 1'b0);
    check("R10 next", addr_o, 17'h1F000);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; load_i = 1'b0; addr_i = '0; step_n_i = 1'b1; order_sel_i = 1'b0;
    @(negedge clk);
    t_reset();
    run_burst(17'h00001, 1'b0, "R5 lin s1");
    run_burst(17'h1FFFF, 1'b0, "R7 lin s3 upper");
    run_burst(17'h05551, 1'b1, "R6 xor s1");
    run_burst(17'h0AAA2, 1'b1, "R6 xor s2");
    run_burst(17'h1FFFC, 1'b0, "R5 lin s0");
    t_load_ignores_step();
    t_hold();
    t_reload();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule